// File: doc/BRIEF.md
# PLL Divider Setting Search Engine

This block picks the settings of a clock synthesiser, made of an input pre-divider M, a feedback multiplier N, a power-of-two post-divider 2^E and an integer output divider DIV, that bring the output nearest to a requested pixel frequency. Up to three reference inputs can drive the synthesiser. Each input has its own frequency and valid bit. The engine walks every legal combination in a fixed nested order. It keeps the candidate with the smallest error and stops early once a candidate has zero error. It then presents the winning settings, the two packed control words and a one-cycle completion pulse.

A request is a single-cycle `start` pulse in the idle state. The clamped target and the dot-clock flag are captured at that pulse. The source frequencies and valid bits must stay stable until `done`. Every quotient the search needs (range bounds, the phase-detector frequency, the serial /7 step, the divider choice and the resulting output) comes from one shared multi-bit-per-cycle restoring divider. A search therefore takes thousands of cycles, not one.

Top module: `pll_search`

## Requirements
- R1: After reset, `done`, `found`, `err_hz`, `pll_word` and `div_word` are all zero.
- R2: Sources are tried in the order 0, 1, 2. A source is skipped if its valid bit is low or its frequency lies outside 12,000,000..192,000,000 Hz; both bounds are accepted. `sel_src` reports the index of the winning source.
- R3: For a source at Fin, M runs from max(1, ceil(Fin/24 MHz)) to min(8, floor(Fin/12 MHz)). With Fpfd = floor(Fin/M), N runs from max(60, ceil(900 MHz/Fpfd)) up to but excluding min(120, floor(1800 MHz/Fpfd)). E runs 0..2, and E starts at 1 when Fpfd*N exceeds 1,039,500,000 Hz.
- R4: Fout = floor(Fpfd*N / 2^E). This is then divided (floor) by 7 unless the dot-clock flag latched at start is set.
- R5: DIV = floor((Fout + floor(T/2)) / T), raised to 1 if it is 0. The error is |floor(Fout/DIV) − T|. The reported result has the smallest error over the whole search.
- R6: A candidate replaces the best only when its error is strictly smaller, so the first one in search order wins a tie. The search stops at the first zero-error candidate.
- R7: The target T is the input clamped to MIN_TGT_HZ..MAX_TGT_HZ (defaults 5,000,000 and 148,500,000 Hz) at start.
- R8: When a setting is found, `pll_word` has these fields: bit 0 = 1 (synthesiser on); bits 2:1 = source index; bits 9:3 = N−1; bits 12:10 = M−1; bit 16 = dot-clock flag. Bit 13 = 1 and bits 15:14 = E−1 appear only when E > 0; otherwise those bits are 0.
- R9: When a setting is found and DIV > 1, `div_word` bits 9:0 = DIV−1, bit 10 = divider enable = 1, bit 11 = divider run = 1. Otherwise `div_word` is zero.
- R10: If no source qualifies, `found` is 0 at `done`, `err_hz` is all ones, and both words are zero.
- R11: `done` is high for exactly one cycle per search. While the engine is idle, the outputs hold their values. A `start` pulse during a search is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (taken only when idle) |
| target_hz | input | 32 | Requested pixel frequency in Hz |
| dot_only | input | 1 | Bypass the /7 serialiser step |
| src_hz | input | 96 | Three 32-bit reference frequencies, source 0 in the low bits |
| src_vld | input | 3 | Per-source valid bits |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A legal setting was found |
| sel_src | output | 2 | Chosen source index |
| m_out | output | 4 | Chosen pre-divider M |
| n_out | output | 7 | Chosen multiplier N |
| e_out | output | 2 | Chosen post-divider exponent E |
| div_out | output | 10 | Chosen output divider DIV |
| err_hz | output | 32 | Absolute error of the chosen setting |
| pll_word | output | 32 | Packed synthesiser control word |
| div_word | output | 32 | Packed output-divider control word |

## Verification
Two things can happen in the same cycle: the best-so-far register is updated, and the search ends early on a zero-error candidate. They are provoked together by a 24 MHz source with the dot-clock flag set and a 72 MHz target. The exact hit comes at the first legal N. The test checks that the first source is reported with zero error, even though a second valid source follows. Equal-frequency sources check that a tie keeps the earlier source. A start pulse injected mid-search must leave the result identical to a bench model that never saw it.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
    localparam int unsigned FW     = 32;
    localparam int unsigned M_W    = 4;
    localparam int unsigned N_W    = 7;
    localparam int unsigned E_W    = 2;

    localparam logic [FW-1:0] REF_LO_HZ  = 32'd12_000_000;
    localparam logic [FW-1:0] REF_HI_HZ  = 32'd192_000_000;
    localparam logic [FW-1:0] PFD_LO_HZ  = 32'd12_000_000;
    localparam logic [FW-1:0] PFD_HI_HZ  = 32'd24_000_000;
    localparam logic [FW-1:0] VCO_LO_HZ  = 32'd900_000_000;
    localparam logic [FW-1:0] VCO_HI_HZ  = 32'd1_800_000_000;
    localparam logic [FW-1:0] E0_CAP_HZ  = 32'd1_039_500_000;

    localparam logic [M_W-1:0] M_CAP   = 4'd8;
    localparam logic [N_W-1:0] N_FLOOR = 7'd60;
    localparam logic [N_W-1:0] N_CAP   = 7'd120;
    localparam logic [E_W-1:0] E_END   = 2'd3;
    localparam logic [FW-1:0]  SER_DIV = 32'd7;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SRC, ST_MLO, ST_MHI, ST_MCHK, ST_FPFD, ST_NLO,
        ST_NHI, ST_NCHK, ST_ECHK, ST_F7, ST_DIVR, ST_QUO, ST_DONE
    } srch_st_e;
endpackage

// File: rtl/pll_srch_div.sv
module pll_srch_div #(
    parameter int unsigned W    = 32,
    parameter int unsigned STEP = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         vld,
    output logic [W-1:0] quo
);
    localparam int unsigned CYC = W / STEP;
    localparam int unsigned CW  = $clog2(CYC + 1);

    typedef struct packed {
        logic          busy;
        logic          vld;
        logic [CW-1:0] cnt;
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
    } dv_t;

    dv_t dv_d, dv_q;

    always_comb begin
        logic [W:0]   r;
        logic [W-1:0] qq;
        dv_d     = dv_q;
        dv_d.vld = 1'b0;
        r        = dv_q.rem;
        qq       = dv_q.quo;
        if (dv_q.busy) begin
            for (int i = 0; i < STEP; i++) begin
                r  = {r[W-1:0], qq[W-1]};
                qq = {qq[W-2:0], 1'b0};
                if (r >= {1'b0, dv_q.den}) begin
                    r     = r - {1'b0, dv_q.den};
                    qq[0] = 1'b1;
                end
            end
            dv_d.rem = r;
            dv_d.quo = qq;
            dv_d.cnt = dv_q.cnt - 1'b1;
            if (dv_q.cnt == CW'(1)) begin
                dv_d.busy = 1'b0;
                dv_d.vld  = 1'b1;
            end
        end else if (go) begin
            dv_d.busy = 1'b1;
            dv_d.rem  = '0;
            dv_d.quo  = num;
            dv_d.den  = den;
            dv_d.cnt  = CW'(CYC);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign vld = dv_q.vld;
    assign quo = dv_q.quo;
endmodule

// File: rtl/pll_srch_pack.sv
module pll_srch_pack
    import pll_srch_pkg::*;
#(
    parameter int unsigned SRC_W = 2,
    parameter int unsigned DIV_W = 10
) (
    input  logic             found,
    input  logic             dot,
    input  logic [SRC_W-1:0] src,
    input  logic [M_W-1:0]   m,
    input  logic [N_W-1:0]   n,
    input  logic [E_W-1:0]   e,
    input  logic [DIV_W-1:0] dv,
    output logic [FW-1:0]    pll_word,
    output logic [FW-1:0]    div_word
);
    localparam int unsigned M_FLD = 3;
    localparam int unsigned P_SRC = 1;
    localparam int unsigned P_N   = P_SRC + SRC_W;
    localparam int unsigned P_M   = P_N + N_W;
    localparam int unsigned P_EON = P_M + M_FLD;
    localparam int unsigned P_E   = P_EON + 1;
    localparam int unsigned P_DOT = P_E + E_W;

    always_comb begin
        logic [M_W-1:0] m1;
        logic [E_W-1:0] e1;
        m1       = m - 1'b1;
        e1       = e - 1'b1;
        pll_word = '0;
        div_word = '0;
        if (found) begin
            pll_word[0]              = 1'b1;
            pll_word[P_SRC +: SRC_W] = src;
            pll_word[P_N +: N_W]     = n - 1'b1;
            pll_word[P_M +: M_FLD]   = m1[M_FLD-1:0];
            pll_word[P_DOT]          = dot;
            if (e != '0) begin
                pll_word[P_EON]      = 1'b1;
                pll_word[P_E +: E_W] = e1;
            end
            if (dv > DIV_W'(1)) begin
                div_word[DIV_W-1:0] = dv - 1'b1;
                div_word[DIV_W]     = 1'b1;
                div_word[DIV_W+1]   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pll_search.sv
module pll_search
    import pll_srch_pkg::*;
#(
    parameter int unsigned NSRC       = 3,
    parameter int unsigned DIV_W      = 10,
    parameter int unsigned STEP_BITS  = 8,
    parameter logic [31:0] MIN_TGT_HZ = 32'd5_000_000,
    parameter logic [31:0] MAX_TGT_HZ = 32'd148_500_000,
    localparam int unsigned SRC_W     = $clog2(NSRC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [31:0]         target_hz,
    input  logic                dot_only,
    input  logic [NSRC*32-1:0]  src_hz,
    input  logic [NSRC-1:0]     src_vld,
    output logic                done,
    output logic                found,
    output logic [SRC_W-1:0]    sel_src,
    output logic [3:0]          m_out,
    output logic [6:0]          n_out,
    output logic [1:0]          e_out,
    output logic [DIV_W-1:0]    div_out,
    output logic [31:0]         err_hz,
    output logic [31:0]         pll_word,
    output logic [31:0]         div_word
);
    localparam int unsigned NSLOT = 2 ** SRC_W;

    typedef struct packed {
        srch_st_e         st;
        logic [SRC_W-1:0] src;
        logic             dot;
        logic [FW-1:0]    tgt;
        logic [FW-1:0]    fin;
        logic [M_W-1:0]   mm;
        logic [M_W-1:0]   m_hi;
        logic [FW-1:0]    fpfd;
        logic [N_W-1:0]   nn;
        logic [N_W-1:0]   n_hi;
        logic [E_W-1:0]   ee;
        logic [FW-1:0]    fout;
        logic [DIV_W-1:0] dv;
        logic             found;
        logic [SRC_W-1:0] b_src;
        logic [M_W-1:0]   b_m;
        logic [N_W-1:0]   b_n;
        logic [E_W-1:0]   b_e;
        logic [DIV_W-1:0] b_dv;
        logic [FW-1:0]    b_err;
    } srch_t;

    srch_t st_d, st_q;

    logic [FW-1:0] src_arr [NSLOT];
    logic          vld_arr [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        if (g < NSRC) begin : g_real
            assign src_arr[g] = src_hz[g*FW +: FW];
            assign vld_arr[g] = src_vld[g];
        end else begin : g_pad
            assign src_arr[g] = '0;
            assign vld_arr[g] = 1'b0;
        end
    end

    logic          dgo, dvld;
    logic [FW-1:0] dnum, dden, dquo;

    pll_srch_div #(.W(FW), .STEP(STEP_BITS)) div_i (
        .clk (clk), .rst_n(rst_n), .go(dgo), .num(dnum), .den(dden),
        .vld (dvld), .quo(dquo)
    );

    always_comb begin
        logic [FW-1:0] fvco, fo, fcur, dsel, absd;
        st_d = st_q;
        dgo  = 1'b0;
        dnum = '0;
        dden = 32'd1;
        fvco = st_q.fpfd * {{(FW-N_W){1'b0}}, st_q.nn};
        fo   = fvco >> st_q.ee;
        fcur = src_arr[st_q.src];
        dsel = (dquo == '0) ? 32'd1 : dquo;
        absd = (dquo >= st_q.tgt) ? dquo - st_q.tgt : st_q.tgt - dquo;
        unique case (st_q.st)
            ST_IDLE: if (start) begin
                st_d       = '0;
                st_d.st    = ST_SRC;
                st_d.dot   = dot_only;
                st_d.b_err = '1;
                st_d.tgt   = (target_hz < MIN_TGT_HZ) ? MIN_TGT_HZ :
                             (target_hz > MAX_TGT_HZ) ? MAX_TGT_HZ : target_hz;
            end
            ST_SRC: begin
                if (st_q.src == SRC_W'(NSRC)) begin
                    st_d.st = ST_DONE;
                end else if (!vld_arr[st_q.src] || fcur < REF_LO_HZ || fcur > REF_HI_HZ) begin
                    st_d.src = st_q.src + 1'b1;
                end else begin
                    st_d.fin = fcur;
                    dgo      = 1'b1;
                    dnum     = fcur + PFD_HI_HZ - 32'd1;
                    dden     = PFD_HI_HZ;
                    st_d.st  = ST_MLO;
                end
            end
            ST_MLO: if (dvld) begin
                st_d.mm = (dquo == '0) ? M_W'(1) : dquo[M_W-1:0];
                dgo     = 1'b1;
                dnum    = st_q.fin;
                dden    = PFD_LO_HZ;
                st_d.st = ST_MHI;
            end
            ST_MHI: if (dvld) begin
                st_d.m_hi = (dquo > {{(FW-M_W){1'b0}}, M_CAP}) ? M_CAP : dquo[M_W-1:0];
                st_d.st   = ST_MCHK;
            end
            ST_MCHK: begin
                if (st_q.mm > st_q.m_hi) begin
                    st_d.src = st_q.src + 1'b1;
                    st_d.st  = ST_SRC;
                end else begin
                    dgo     = 1'b1;
                    dnum    = st_q.fin;
                    dden    = {{(FW-M_W){1'b0}}, st_q.mm};
                    st_d.st = ST_FPFD;
                end
            end
            ST_FPFD: if (dvld) begin
                st_d.fpfd = dquo;
                dgo       = 1'b1;
                dnum      = VCO_LO_HZ + dquo - 32'd1;
                dden      = dquo;
                st_d.st   = ST_NLO;
            end
            ST_NLO: if (dvld) begin
                st_d.nn = (dquo < {{(FW-N_W){1'b0}}, N_FLOOR}) ? N_FLOOR : dquo[N_W-1:0];
                dgo     = 1'b1;
                dnum    = VCO_HI_HZ;
                dden    = st_q.fpfd;
                st_d.st = ST_NHI;
            end
            ST_NHI: if (dvld) begin
                st_d.n_hi = (dquo > {{(FW-N_W){1'b0}}, N_CAP}) ? N_CAP : dquo[N_W-1:0];
                st_d.st   = ST_NCHK;
            end
            ST_NCHK: begin
                if (st_q.nn >= st_q.n_hi) begin
                    st_d.mm = st_q.mm + 1'b1;
                    st_d.st = ST_MCHK;
                end else begin
                    st_d.ee = (fvco > E0_CAP_HZ) ? E_W'(1) : E_W'(0);
                    st_d.st = ST_ECHK;
                end
            end
            ST_ECHK: begin
                if (st_q.ee == E_END) begin
                    st_d.nn = st_q.nn + 1'b1;
                    st_d.st = ST_NCHK;
                end else if (st_q.dot) begin
                    st_d.fout = fo;
                    dgo       = 1'b1;
                    dnum      = fo + (st_q.tgt >> 1);
                    dden      = st_q.tgt;
                    st_d.st   = ST_DIVR;
                end else begin
                    dgo     = 1'b1;
                    dnum    = fo;
                    dden    = SER_DIV;
                    st_d.st = ST_F7;
                end
            end
            ST_F7: if (dvld) begin
                st_d.fout = dquo;
                dgo       = 1'b1;
                dnum      = dquo + (st_q.tgt >> 1);
                dden      = st_q.tgt;
                st_d.st   = ST_DIVR;
            end
            ST_DIVR: if (dvld) begin
                st_d.dv = dsel[DIV_W-1:0];
                dgo     = 1'b1;
                dnum    = st_q.fout;
                dden    = dsel;
                st_d.st = ST_QUO;
            end
            ST_QUO: if (dvld) begin
                st_d.ee = st_q.ee + 1'b1;
                st_d.st = ST_ECHK;
                if (absd < st_q.b_err) begin
                    st_d.found = 1'b1;
                    st_d.b_src = st_q.src;
                    st_d.b_m   = st_q.mm;
                    st_d.b_n   = st_q.nn;
                    st_d.b_e   = st_q.ee;
                    st_d.b_dv  = st_q.dv;
                    st_d.b_err = absd;
                    if (absd == '0) st_d.st = ST_DONE;
                end
            end
            ST_DONE: st_d.st = ST_IDLE;
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic idle_w;
    assign idle_w  = (st_q.st == ST_IDLE);
    assign done    = (st_q.st == ST_DONE);
    assign found   = st_q.found;
    assign sel_src = st_q.b_src;
    assign m_out   = st_q.b_m;
    assign n_out   = st_q.b_n;
    assign e_out   = st_q.b_e;
    assign div_out = st_q.b_dv;
    assign err_hz  = st_q.b_err;

    pll_srch_pack #(.SRC_W(SRC_W), .DIV_W(DIV_W)) pack_i (
        .found(st_q.found), .dot(st_q.dot), .src(st_q.b_src), .m(st_q.b_m),
        .n(st_q.b_n), .e(st_q.b_e), .dv(st_q.b_dv),
        .pll_word(pll_word), .div_word(div_word)
    );
endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk #(
    parameter int unsigned SRC_W = 2,
    parameter int unsigned DIV_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             idle,
    input logic             done,
    input logic             found,
    input logic [SRC_W-1:0] sel_src,
    input logic [3:0]       m_out,
    input logic [6:0]       n_out,
    input logic [DIV_W-1:0] div_out,
    input logic [31:0]      err_hz,
    input logic [31:0]      pll_word,
    input logic [31:0]      div_word
);
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start) |=> ($stable(err_hz) && $stable(pll_word) && $stable(div_word)));
    a_r3_m_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (m_out >= 4'd1 && m_out <= 4'd8));
    a_r3_n_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (n_out >= 7'd60 && n_out < 7'd120));
    a_r5_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (div_out != '0));
    a_r2_src_index: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (sel_src < SRC_W'(3)));
    a_r10_none_found: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (pll_word == '0 && div_word == '0 && err_hz == '1));
    a_r9_unit_div: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found && div_out == DIV_W'(1)) |-> (div_word == '0));
    a_r8_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> pll_word[0]);
endmodule

bind pll_search pll_search_chk #(.SRC_W(SRC_W), .DIV_W(DIV_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(idle_w), .done(done),
    .found(found), .sel_src(sel_src), .m_out(m_out), .n_out(n_out),
    .div_out(div_out), .err_hz(err_hz), .pll_word(pll_word), .div_word(div_word)
);

// File: tb/pll_search_tb_top.sv
module pll_search_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 10;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, dot_only = 1'b0;
    logic [31:0] target_hz = '0;
    logic [95:0] src_hz = '0;
    logic [2:0]  src_vld = '0;
    logic        done, found;
    logic [1:0]  sel_src, e_out;
    logic [3:0]  m_out;
    logic [6:0]  n_out;
    logic [DIV_W-1:0] div_out;
    logic [31:0] err_hz, pll_word, div_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_search dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
        .dot_only(dot_only), .src_hz(src_hz), .src_vld(src_vld), .done(done),
        .found(found), .sel_src(sel_src), .m_out(m_out), .n_out(n_out),
        .e_out(e_out), .div_out(div_out), .err_hz(err_hz),
        .pll_word(pll_word), .div_word(div_word)
    );

    int nchk = 0, nerr = 0;
    bit finished = 0;

    typedef struct {
        bit found;
        longint unsigned src, m, n, e, dv, err;
    } exp_t;

    function automatic longint unsigned clampt(longint unsigned t);
        if (t < 5_000_000) return 5_000_000;    // R7
        if (t > 148_500_000) return 148_500_000;
        return t;
    endfunction

    function automatic exp_t model(longint unsigned t, bit dot, longint unsigned f[3], bit [2:0] v);
        exp_t r;
        r.found = 0; r.src = 0; r.m = 0; r.n = 0; r.e = 0; r.dv = 0; r.err = 32'hFFFF_FFFF;
        for (int s = 0; s < 3; s++) begin
            longint unsigned mlo, mhi;
            if (!v[s] || f[s] < 12_000_000 || f[s] > 192_000_000) continue;
            mlo = (f[s] + 23_999_999) / 24_000_000; if (mlo < 1) mlo = 1;
            mhi = f[s] / 12_000_000; if (mhi > 8) mhi = 8;
            for (longint unsigned m = mlo; m <= mhi; m++) begin
                longint unsigned fp, nlo, nhi;
                fp  = f[s] / m;
                nlo = (900_000_000 + fp - 1) / fp; if (nlo < 60) nlo = 60;
                nhi = 1_800_000_000 / fp; if (nhi > 120) nhi = 120;
                for (longint unsigned n = nlo; n < nhi; n++) begin
                    longint unsigned fv;
                    fv = fp * n;
                    for (longint unsigned e = (fv > 1_039_500_000) ? 1 : 0; e < 3; e++) begin
                        longint unsigned fo, dv, q, df;
                        fo = fv >> e;
                        if (!dot) fo = fo / 7;
                        dv = (fo + t / 2) / t; if (dv == 0) dv = 1;
                        q  = fo / dv;
                        df = (q >= t) ? q - t : t - q;
                        if (df < r.err) begin
                            r.found = 1; r.src = s; r.m = m; r.n = n; r.e = e; r.dv = dv; r.err = df;
                            if (df == 0) return r;
                        end
                    end
                end
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_pll(exp_t r, bit dot);
        logic [31:0] w = '0;
        if (r.found) begin
            w[0] = 1'b1; w[2:1] = 2'(r.src); w[9:3] = 7'(r.n - 1); w[12:10] = 3'(r.m - 1);
            w[16] = dot;
            if (r.e > 0) begin w[13] = 1'b1; w[15:14] = 2'(r.e - 1); end
        end
        return w;
    endfunction

    function automatic logic [31:0] exp_div(exp_t r);
        logic [31:0] w = '0;
        if (r.found && r.dv > 1) begin w[9:0] = 10'(r.dv - 1); w[10] = 1'b1; w[11] = 1'b1; end
        return w;
    endfunction

    task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(string nm, longint unsigned t, bit dot, longint unsigned f0,
                       longint unsigned f1, longint unsigned f2, bit [2:0] v, bit poke,
                       output exp_t r);
        longint unsigned f[3];
        int w;
        logic [31:0] pw_s;
        f[0] = f0; f[1] = f1; f[2] = f2;
        r = model(clampt(t), dot, f, v);
        @(negedge clk);
        target_hz = 32'(t); dot_only = dot; src_vld = v;
        src_hz = {32'(f2), 32'(f1), 32'(f0)};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        if (poke) begin
            repeat (30) @(negedge clk);
            target_hz = 32'd7_000_000; dot_only = ~dot; start = 1'b1;   // R11 mid-search start
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && w < 60000) begin @(negedge clk); w++; end
        if (!done) begin chk(0, {nm, " R11 done never seen"}, 0, 1); return; end
        chk(found == r.found, {nm, " R10 found"}, found, r.found);
        chk(err_hz == 32'(r.err), {nm, " R5 error"}, err_hz, r.err);
        if (r.found) begin
            chk(sel_src == 2'(r.src), {nm, " R2 source"}, sel_src, r.src);
            chk(m_out == 4'(r.m), {nm, " R3 M"}, m_out, r.m);
            chk(n_out == 7'(r.n), {nm, " R3 N"}, n_out, r.n);
            chk(e_out == 2'(r.e), {nm, " R3 E"}, e_out, r.e);
            chk(div_out == DIV_W'(r.dv), {nm, " R5 DIV"}, div_out, r.dv);
        end
        chk(pll_word == exp_pll(r, dot), {nm, " R8 pll word"}, pll_word, exp_pll(r, dot));
        chk(div_word == exp_div(r), {nm, " R9 div word"}, div_word, exp_div(r));
        pw_s = pll_word;
        @(negedge clk);
        chk(done == 1'b0, {nm, " R11 done pulse"}, done, 0);
        chk(pll_word == pw_s, {nm, " R11 hold"}, pll_word, pw_s);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        exp_t r;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 0 && found == 0, "R1 reset flags", {done, found}, 0);
        chk(pll_word == 0 && div_word == 0 && err_hz == 0, "R1 reset words", pll_word, 0);

        // R6 early exit and best update together: exact hit on source 0
        run("exact", 72_000_000, 1, 24_000_000, 27_000_000, 0, 3'b011, 0, r);
        chk(r.err == 0 && r.src == 0, "R6 zero error first source", r.src, 0);
        // R6 tie keeps earlier source
        run("tie", 65_000_000, 0, 27_000_000, 27_000_000, 0, 3'b011, 0, r);
        chk(sel_src == 2'd0, "R6 tie source", sel_src, 0);
        // R2 range bounds: below, above, exactly at top
        run("bounds", 40_000_000, 0, 11_999_999, 192_000_001, 192_000_000, 3'b111, 0, r);
        chk(sel_src == 2'd2, "R2 only boundary source", sel_src, 2);
        // R10 nothing qualifies
        run("none", 50_000_000, 0, 100_000_000, 11_000_000, 200_000_000, 3'b110, 0, r);
        chk(found == 0, "R10 no source", found, 0);
        // R7 clamping low and high
        run("clamp_lo", 1_000_000, 1, 20_000_000, 0, 0, 3'b001, 0, r);
        run("clamp_hi", 250_000_000, 0, 33_000_000, 0, 0, 3'b001, 0, r);
        // R4 dot-clock bypass versus serial path
        run("dot", 33_333_333, 1, 48_000_000, 0, 0, 3'b001, 0, r);
        chk(e_out == 0 || 64'(n_out) * (48_000_000 / 64'(m_out)) > 0, "R3 E legal", e_out, r.e);
        run("ser", 33_333_333, 0, 48_000_000, 0, 0, 3'b001, 0, r);
        // R11 start during search ignored
        run("poke", 61_000_000, 0, 26_000_000, 0, 0, 3'b001, 1, r);
        // random cases
        for (int i = 0; i < 4; i++) begin
            longint unsigned t, a;
            bit [2:0] v;
            t = 2_000_000 + ($urandom % 160_000_000);
            a = 10_000_000 + ($urandom % 190_000_000);
            v = 3'b001 << ($urandom % 3);
            run("rand", t, 1'($urandom % 2), a, a, a, v, 0, r);
        end
        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule